// File: doc/BRIEF.md
# Channel Status Word Capture

This block sits behind the clock-recovery and biphase-decoding stages of a digital audio receiver. It collects the channel status bits that arrive one per frame. A channel status block spans 192 frames, and the block keeps only the first 32 bits of each one. Once the last of those 32 bits arrives, the whole word is copied into a holding register. A host microcontroller then reads the holding register through a chip-select-framed serial port, least significant bit first.

The block does no checking of any kind on the bits. It does not check a CRC, it does not judge validity, and it does not compare a new word with the previous one. When the recovery loop reports loss of lock, all captured state is wiped. Capture resumes only at the first block-start marker that follows the return of lock.

The status flag has two behaviours, chosen by an interface-mode input. With the mode high, the flag is held high. With the mode low, the flag goes high once a complete word has been latched since the last reset or loss of lock.

Top module: `chstat_capture`

## Requirements
- R1: After a block-start marker, the C bits of frames 0 to 31 of that block are stored so that frame n's bit is word bit n. A host read returns word bit 0 first, then bit 1, and so on up to bit 31.
- R2: C bits of frames 32 to 191 of a block have no effect on the word that a host read returns.
- R3: The readable word changes only when bit 31 of a block has been captured. A read during frames 0 to 30 of a block returns the previous complete word.
- R4: A host read starts on the falling edge of chip select, which loads the word. Each rising shift-clock edge with chip select low moves to the next bit. Shift clocks beyond the 32nd output 0.
- R5: While lock is low, the captured bits, the holding register and the output shifter are cleared. A later read returns 0, and with the interface mode low the status flag reads 0.
- R6: Frames received after lock returns are ignored until a block-start marker arrives. A block-start marker in the middle of a capture restarts capture at bit 0.
- R7: With the interface mode high, the status flag is 1 in every cycle.
- R8: With the interface mode low, the status flag is 1 exactly when a complete word has been latched since the last reset or loss of lock.
- R9: After reset, the serial output is 0, the status flag (interface mode low) is 0, and a read returns all zeros.
- R10: The serial output is 0 whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_ok | input | 1 | Clock-recovery lock status, high when locked |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| cbit_in | input | 1 | Channel status bit of the current frame, valid with frame_stb |
| blk_start | input | 1 | Marks frame 0 of a block, valid with frame_stb |
| if_mode | input | 1 | Interface mode; high forces the status flag high |
| host_cs_n | input | 1 | Host chip select, active low, synchronous to clk |
| host_sck | input | 1 | Host shift clock, synchronous to clk, rising edge advances |
| host_sdo | output | 1 | Serial data to host |
| status_flag | output | 1 | Word-ready flag, or constant high in mode high |

## Verification
A wrong frame index or a wrong arming state shows up as a misplaced or missing bit in the next host read, as soon as bit 31 of the following block lands. A holding register that updates early shows up as a mixed word in a read taken in the middle of a block. A stale shifter or a stale valid bit left over after lock loss shows up right away: the status flag stays high, or a read returns nonzero data. The bench compares the serial output and the flag against a behavioural model on every clock, so any of these faults is reported in the cycle where it first reaches a port.

// File: rtl/chstat_pkg.sv
package chstat_pkg;
    // default number of channel status bits kept per block
    localparam int unsigned CS_KEEP_DEF = 32;
endpackage

// File: rtl/chstat_framer.sv
module chstat_framer #(
    parameter int unsigned W = chstat_pkg::CS_KEEP_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lock_ok,
    input  logic         frame_stb,
    input  logic         cbit,
    input  logic         blk_start,
    output logic [W-1:0] hold_o,
    output logic         valid_o
);
    localparam int unsigned IW = $clog2(W + 1);
    localparam int unsigned PW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [W-1:0]  cap;
        logic [IW-1:0] idx;
        logic          armed;
        logic [W-1:0]  hold;
        logic          valid;
    } fr_st_t;

    fr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!lock_ok) begin
            st_d = '0;
        end else if (frame_stb) begin
            if (blk_start) begin
                st_d.cap    = '0;
                st_d.cap[0] = cbit;
                st_d.idx    = IW'(1);
                st_d.armed  = 1'b1;
            end else if (st_q.armed && (st_q.idx < IW'(W))) begin
                st_d.cap[st_q.idx[PW-1:0]] = cbit;
                st_d.idx = st_q.idx + 1'b1;
            end
            if (st_d.armed && (st_d.idx == IW'(W))) begin
                st_d.hold  = st_d.cap;
                st_d.valid = 1'b1;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o  = st_q.hold;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/chstat_shiftout.sv
module chstat_shiftout #(
    parameter int unsigned W = chstat_pkg::CS_KEEP_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lock_ok,
    input  logic [W-1:0] word_i,
    input  logic         cs_n,
    input  logic         sck,
    output logic         sdo
);
    typedef struct packed {
        logic [W-1:0] sr;
        logic         cs_n_prev;
        logic         sck_prev;
    } sh_st_t;

    localparam sh_st_t SH_RESET = '{sr: '0, cs_n_prev: 1'b1, sck_prev: 1'b0};

    sh_st_t sh_d, sh_q;

    always_comb begin
        sh_d           = sh_q;
        sh_d.cs_n_prev = cs_n;
        sh_d.sck_prev  = sck;
        if (!lock_ok) begin
            sh_d.sr = '0;
        end else if (!cs_n && sh_q.cs_n_prev) begin
            sh_d.sr = word_i;
        end else if (!cs_n && sck && !sh_q.sck_prev) begin
            sh_d.sr = sh_q.sr >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= SH_RESET;
        else        sh_q <= sh_d;
    end

    assign sdo = !cs_n && sh_q.sr[0];
endmodule

// File: rtl/chstat_capture.sv
module chstat_capture #(
    parameter int unsigned CAP_W = chstat_pkg::CS_KEEP_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_ok,
    input  logic frame_stb,
    input  logic cbit_in,
    input  logic blk_start,
    input  logic if_mode,
    input  logic host_cs_n,
    input  logic host_sck,
    output logic host_sdo,
    output logic status_flag
);
    logic [CAP_W-1:0] hold_w;
    logic             valid_w;

    chstat_framer #(.W(CAP_W)) framer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_ok   (lock_ok),
        .frame_stb (frame_stb),
        .cbit      (cbit_in),
        .blk_start (blk_start),
        .hold_o    (hold_w),
        .valid_o   (valid_w)
    );

    chstat_shiftout #(.W(CAP_W)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_ok (lock_ok),
        .word_i  (hold_w),
        .cs_n    (host_cs_n),
        .sck     (host_sck),
        .sdo     (host_sdo)
    );

    assign status_flag = if_mode || valid_w;
endmodule

// File: rtl/chstat_capture_chk.sv
module chstat_capture_chk #(
    parameter int unsigned W = chstat_pkg::CS_KEEP_DEF
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lock_ok,
    input logic         frame_stb,
    input logic         if_mode,
    input logic         host_cs_n,
    input logic         host_sdo,
    input logic         status_flag,
    input logic [W-1:0] hold
);
    // R10
    sdo_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_cs_n |-> !host_sdo);

    // R7
    flag_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        if_mode |-> status_flag);

    // R5
    lock_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_ok |=> (if_mode || !status_flag));

    // R5
    lock_hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_ok |=> (hold == '0));

    // R3
    hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_ok && !frame_stb) |=> $stable(hold));
endmodule

bind chstat_capture chstat_capture_chk #(.W(CAP_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_ok     (lock_ok),
    .frame_stb   (frame_stb),
    .if_mode     (if_mode),
    .host_cs_n   (host_cs_n),
    .host_sdo    (host_sdo),
    .status_flag (status_flag),
    .hold        (hold_w)
);

// File: tb/chstat_capture_tb.sv
module chstat_capture_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_ok = 1'b1;
    logic frame_stb = 1'b0;
    logic cbit_in = 1'b0;
    logic blk_start = 1'b0;
    logic if_mode = 1'b0;
    logic host_cs_n = 1'b1;
    logic host_sck = 1'b0;
    logic host_sdo;
    logic status_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chstat_capture dut_i (
        .clk(clk), .rst_n(rst_n), .lock_ok(lock_ok), .frame_stb(frame_stb),
        .cbit_in(cbit_in), .blk_start(blk_start), .if_mode(if_mode),
        .host_cs_n(host_cs_n), .host_sck(host_sck),
        .host_sdo(host_sdo), .status_flag(status_flag)
    );

    // behavioural reference: bit list of the block in progress
    bit q_bits[$];
    logic [31:0] m_hold = '0;
    logic [31:0] m_out = '0;
    bit m_armed = 0;
    bit m_valid = 0;
    bit m_csp = 1;
    bit m_sckp = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_bits.delete(); m_hold = '0; m_out = '0; m_armed = 0;
            m_valid = 0; m_csp = 1; m_sckp = 0;
        end else begin
            if (!lock_ok) begin
                m_out = '0;
            end else if (!host_cs_n && m_csp) begin
                m_out = m_hold;
            end else if (!host_cs_n && host_sck && !m_sckp) begin
                m_out = {1'b0, m_out[31:1]};
            end
            if (!lock_ok) begin
                q_bits.delete(); m_hold = '0; m_armed = 0; m_valid = 0;
            end else if (frame_stb) begin
                if (blk_start) begin
                    q_bits.delete(); q_bits.push_back(cbit_in); m_armed = 1;
                end else if (m_armed) begin
                    q_bits.push_back(cbit_in);
                end
                if (m_armed && q_bits.size() == 32) begin
                    for (int i = 0; i < 32; i++) m_hold[i] = q_bits[i];
                    m_valid = 1; m_armed = 0;
                end
            end
            m_csp = host_cs_n;
            m_sckp = host_sck;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock model comparison
    always @(negedge clk) begin
        if (rst_n) begin
            check("R10/R4 model sdo", {63'd0, host_sdo},
                  {63'd0, (!host_cs_n) ? m_out[0] : 1'b0});
            check("R8 model flag", {63'd0, status_flag}, {63'd0, if_mode | m_valid});
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic send_frame(input bit c, input bit bs);
        frame_stb = 1; cbit_in = c; blk_start = bs;
        tick();
        frame_stb = 0; cbit_in = 0; blk_start = 0;
        tick();
    endtask

    // frames 0..nfr-1 of a block: low 32 from w, rest from tail pattern
    task automatic send_block(input logic [31:0] w, input int nfr, input logic [31:0] tail);
        for (int f = 0; f < nfr; f++)
            send_frame(f < 32 ? w[f] : tail[f % 32], f == 0);
    endtask

    task automatic read_word(output logic [63:0] w, input int nclk);
        w = '0;
        host_cs_n = 0;
        tick();
        for (int i = 0; i < nclk; i++) begin
            @(negedge clk);
            w[i] = host_sdo;
            tick(); host_sck = 1;
            tick(); host_sck = 0;
        end
        host_cs_n = 1;
        tick(); tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        tick(); tick(); rst_n = 1; tick();
        @(negedge clk);
        check("R9 sdo after reset", {63'd0, host_sdo}, 64'd0);
        check("R9 flag after reset", {63'd0, status_flag}, 64'd0);
        read_word(rd, 32);
        check("R9 read after reset", rd, 64'd0);
        if_mode = 1; tick(); @(negedge clk);
        check("R7 flag forced high", {63'd0, status_flag}, 64'd1);
        if_mode = 0; tick();

        send_block(32'hA5C3_0F71, 192, 32'hFFFF_FFFF);
        read_word(rd, 32);
        check("R1 word A", rd, {32'd0, 32'hA5C3_0F71});
        check("R2 tail ignored A", rd, {32'd0, 32'hA5C3_0F71});
        check("R8 flag after word", {63'd0, status_flag}, 64'd1);

        send_block(32'h8000_0001, 192, 32'h5A5A_1234);
        read_word(rd, 36);
        check("R4 extra clocks zero", rd, {32'd0, 32'h8000_0001});

        send_block(32'h1357_9BDF, 16, 32'h0);
        read_word(rd, 32);
        check("R3 mid-block read old", rd, {32'd0, 32'h8000_0001});
        for (int f = 16; f < 32; f++) send_frame(32'h1357_9BDF >> f, 0);
        read_word(rd, 32);
        check("R3 word after bit 31", rd, {32'd0, 32'h1357_9BDF});

        lock_ok = 0; tick(); tick(); tick();
        lock_ok = 1; tick();
        @(negedge clk);
        check("R5 flag cleared", {63'd0, status_flag}, 64'd0);
        read_word(rd, 32);
        check("R5 read cleared", rd, 64'd0);

        for (int f = 0; f < 40; f++) send_frame(1, 0);
        read_word(rd, 32);
        check("R6 no capture before start", rd, 64'd0);
        check("R6 flag low before start", {63'd0, status_flag}, 64'd0);
        send_block(32'hDEAD_BEEF, 192, 32'h0);
        read_word(rd, 32);
        check("R6 word after relock", rd, {32'd0, 32'hDEAD_BEEF});

        send_block(32'hFFFF_FFFF, 10, 32'h0);
        send_block(32'h0246_8ACE, 192, 32'hFFFF_FFFF);
        read_word(rd, 32);
        check("R6 restart mid-capture", rd, {32'd0, 32'h0246_8ACE});

        host_cs_n = 1; host_sck = 1; tick(); @(negedge clk);
        check("R10 sdo idle", {63'd0, host_sdo}, 64'd0);
        host_sck = 0; tick();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule